// File: doc/BRIEF.md
# Sensorless Startup and Restart Sequencer

This block is the top-level sequencer of a sensorless three-phase motor drive. When a start request is raised, it first holds the rotor in one fixed phase pattern so that it settles into a known position. It then steps the six commutation states open-loop at a fixed rate chosen by a select input. It hands over to closed-loop running, where each back-EMF zero-crossing event advances the step, as soon as two zero-crossings arrive closer together than one forced step period.

While running, the sequencer watches the spacing of zero-crossings. Events that are too close together (overspeed) trip a fault. A gap longer than one forced step period (underspeed) also trips a fault, and so does a startup that never reaches handover in time. In the fault state the power stage is disabled for a parameterised number of cycles, which is about one second at the default clock. The sequencer then starts again from alignment, and does so for as long as faults keep recurring.

The forced step period is P = 2^(BASE_LOG2 + k) clock cycles, so one electrical turn of six steps lasts 6·2^(BASE_LOG2+k) cycles. A "gap" below is the number of clock cycles between the edges at which two zero-crossing events are sampled.

Top module: `spin_seq_top`

## Requirements
- R1: After reset, `mode` is 0 (idle), `step` is 0, `spd_pulse` is 0 and `out_en` is 0. Mode codes are 0 idle, 1 align, 2 forced, 3 run and 4 fault. While `start_req` is low, the sequencer is in idle from the next cycle on, with `out_en` low.
- R2: With `start_req` high in idle, mode becomes align on the next cycle. Align drives `out_en` high and holds `step` at 0 for exactly `align_len` cycles (0 acts as 1), then moves to forced mode.
- R3: In forced mode, `step` counts 0..5 and wraps. It advances once every P cycles, with the first advance P cycles after entry. k is `rate_sel` for values 0, 1 and 2; value 3 acts as 2.
- R4: In forced mode, a zero-crossing whose gap from a previous zero-crossing (both sampled in forced mode) is less than P moves the mode to run on the next cycle and advances `step` by one. A gap of P or more causes no handover.
- R5: If forced mode lasts `force_len` cycles without a handover, the mode becomes fault.
- R6: In run mode, each zero-crossing with a gap of at least `min_gap` advances `step` by one, wrapping from 5 to 0.
- R7: In run mode, a zero-crossing with a gap below `min_gap` moves the mode to fault, and `step` is not advanced.
- R8: In run mode, if P+1 cycles pass after the last zero-crossing with no new one, the mode becomes fault.
- R9: Fault holds `out_en` low for RESTART_CYCLES cycles and then re-enters align. It never goes straight to forced or run mode.
- R10: `spd_pulse` toggles in exactly the cycles in which `step` changes.
- R11: A low `start_req` takes priority over any fault or step event detected in the same cycle. The mode becomes idle, not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Run request; low forces idle |
| align_len | input | TIME_W | Alignment duration in cycles |
| force_len | input | TIME_W | Maximum forced-stepping duration in cycles |
| rate_sel | input | 2 | Forced step rate select (k) |
| zc_evt | input | 1 | One-cycle back-EMF zero-crossing event |
| min_gap | input | TIME_W | Shortest legal zero-crossing gap in run mode |
| mode | output | 3 | Sequencer mode code |
| step | output | 3 | Commutation step 0..5 |
| out_en | output | 1 | Power stage enable |
| spd_pulse | output | 1 | Toggles on every step change |

## Verification
Two decisions can land in the same cycle. One is the release of the start request. The other is a fault detection, either an overspeed zero-crossing in run mode or a forced-mode timeout. The bench provokes the collision by dropping `start_req` on the same clock edge at which a zero-crossing arrives only two cycles after the previous one, with `min_gap` set to 3. It judges the outcome by `mode` reading idle rather than fault on the next cycle, with `out_en` low. A second collision, a forced step tick falling in the cycle of a handover, is avoided by choosing the event timing. The step value after handover then shows a single advance.

// File: rtl/spin_pkg.sv
package spin_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,
        MODE_ALIGN = 3'd1,
        MODE_FORCE = 3'd2,
        MODE_RUN   = 3'd3,
        MODE_FAULT = 3'd4
    } seq_mode_e;

    localparam int unsigned STEP_COUNT = 6;

endpackage

// File: rtl/spin_rate_pick.sv
// Forced step period selection and tick decode from the phase timer.
module spin_rate_pick #(
    parameter int unsigned TIME_W    = 32,
    parameter int unsigned BASE_LOG2 = 16
) (
    input  logic [1:0]        rate_sel,
    input  logic [TIME_W-1:0] tmr,
    output logic [TIME_W-1:0] period,
    output logic              tick
);
    localparam int unsigned MAX_K = 2;

    logic [1:0]        k_eff;
    logic [TIME_W-1:0] mask;

    always_comb begin
        k_eff  = (rate_sel > 2'(MAX_K)) ? 2'(MAX_K) : rate_sel;
        period = TIME_W'(1) << (BASE_LOG2 + k_eff);
        mask   = period - TIME_W'(1);
        tick   = ((tmr & mask) == mask);
    end

endmodule

// File: rtl/spin_zc_mon.sv
// Zero-crossing interval monitor: cycles since last event, gap of the current one.
module spin_zc_mon #(
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              zc,
    output logic [TIME_W-1:0] gap,
    output logic [TIME_W-1:0] idle_cyc,
    output logic              have_prev
);
    typedef struct packed {
        logic [TIME_W-1:0] iv;
        logic              prev;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if (clr) begin
            mon_d.iv   = '0;
            mon_d.prev = 1'b0;
        end else if (zc) begin
            mon_d.iv   = '0;
            mon_d.prev = 1'b1;
        end else if (mon_q.iv != '1) begin
            mon_d.iv = mon_q.iv + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign idle_cyc  = mon_q.iv;
    assign gap       = (mon_q.iv == '1) ? mon_q.iv : mon_q.iv + TIME_W'(1);
    assign have_prev = mon_q.prev;

    AST_ZC_RESTARTS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (zc && !clr) |=> (idle_cyc == '0 && have_prev)); // R6
    AST_CLR_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !have_prev); // R4

endmodule

// File: rtl/spin_seq_top.sv
module spin_seq_top #(
    parameter int unsigned TIME_W         = 32,
    parameter int unsigned BASE_LOG2      = 16,
    parameter int unsigned RESTART_CYCLES = 125_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [TIME_W-1:0] align_len,
    input  logic [TIME_W-1:0] force_len,
    input  logic [1:0]        rate_sel,
    input  logic              zc_evt,
    input  logic [TIME_W-1:0] min_gap,
    output logic [2:0]        mode,
    output logic [2:0]        step,
    output logic              out_en,
    output logic              spd_pulse
);
    import spin_pkg::*;

    localparam logic [TIME_W:0] RESTART_W = (TIME_W+1)'(RESTART_CYCLES);
    localparam logic [2:0]      LAST_STEP = 3'(STEP_COUNT - 1);

    typedef struct packed {
        seq_mode_e         mode;
        logic [2:0]        step;
        logic              spd;
        logic [TIME_W-1:0] tmr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [TIME_W-1:0] period;
    logic              tick;
    logic [TIME_W-1:0] gap;
    logic [TIME_W-1:0] idle_cyc;
    logic              have_prev;
    logic              mon_clr;
    logic [TIME_W:0]   tmr_next;
    logic              handover;
    logic              adv;
    seq_mode_e         go;

    spin_rate_pick #(.TIME_W(TIME_W), .BASE_LOG2(BASE_LOG2)) rate_i (
        .rate_sel (rate_sel),
        .tmr      (seq_q.tmr),
        .period   (period),
        .tick     (tick)
    );

    assign mon_clr = (seq_q.mode != MODE_FORCE) && (seq_q.mode != MODE_RUN);

    spin_zc_mon #(.TIME_W(TIME_W)) mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mon_clr),
        .zc        (zc_evt),
        .gap       (gap),
        .idle_cyc  (idle_cyc),
        .have_prev (have_prev)
    );

    always_comb begin
        seq_d    = seq_q;
        adv      = 1'b0;
        go       = seq_q.mode;
        tmr_next = {1'b0, seq_q.tmr} + (TIME_W+1)'(1);
        handover = zc_evt && have_prev && (gap < period);

        case (seq_q.mode)
            MODE_IDLE: begin
                if (start_req) go = MODE_ALIGN;
            end
            MODE_ALIGN: begin
                if (tmr_next >= {1'b0, align_len}) go = MODE_FORCE;
            end
            MODE_FORCE: begin
                if (handover) begin
                    go  = MODE_RUN;
                    adv = 1'b1;
                end else if (tmr_next >= {1'b0, force_len}) begin
                    go = MODE_FAULT;
                end else if (tick) begin
                    adv = 1'b1;
                end
            end
            MODE_RUN: begin
                if (zc_evt) begin
                    if (gap < min_gap) go = MODE_FAULT;
                    else               adv = 1'b1;
                end else if (idle_cyc >= period) begin
                    go = MODE_FAULT;
                end
            end
            MODE_FAULT: begin
                if (tmr_next >= RESTART_W) go = MODE_ALIGN;
            end
            default: go = MODE_IDLE;
        endcase

        if (!start_req) begin
            go  = MODE_IDLE;
            adv = 1'b0;
        end

        seq_d.mode = go;
        if (go != seq_q.mode)      seq_d.tmr = '0;
        else if (seq_q.tmr != '1)  seq_d.tmr = seq_q.tmr + TIME_W'(1);

        if (go == MODE_IDLE || go == MODE_ALIGN) seq_d.step = 3'd0;
        else if (adv) seq_d.step = (seq_q.step == LAST_STEP) ? 3'd0 : seq_q.step + 3'd1;

        seq_d.spd = seq_q.spd ^ (seq_d.step != seq_q.step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{mode: MODE_IDLE, step: 3'd0, spd: 1'b0, tmr: '0};
        else        seq_q <= seq_d;
    end

    assign mode      = seq_q.mode;
    assign step      = seq_q.step;
    assign spd_pulse = seq_q.spd;
    assign out_en    = (seq_q.mode == MODE_ALIGN) || (seq_q.mode == MODE_FORCE) ||
                       (seq_q.mode == MODE_RUN);

    AST_RELEASE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !start_req |=> (mode == 3'd0 && !out_en)); // R11
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP); // R3
    AST_ALIGN_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> (step == 3'd0)); // R2
    AST_RUN_FROM_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && $past(mode) != 3'd3) |-> ($past(mode) == 3'd2)); // R4
    AST_FAULT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> (mode == 3'd4 || mode == 3'd1 || mode == 3'd0)); // R9
    AST_OVERSPEED_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && start_req && zc_evt && gap < min_gap) |=> (mode == 3'd4 && $stable(step))); // R7

endmodule

// File: tb/spin_seq_top_tb_top.sv
module spin_seq_top_tb_top;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic [TW-1:0] align_len = 16'd10;
    logic [TW-1:0] force_len = 16'd300;
    logic [1:0]    rate_sel = 2'd0;
    logic          zc_evt = 1'b0;
    logic [TW-1:0] min_gap = 16'd3;
    logic [2:0]    mode;
    logic [2:0]    step;
    logic          out_en;
    logic          spd_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    spin_seq_top #(.TIME_W(TW), .BASE_LOG2(3), .RESTART_CYCLES(50)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .align_len(align_len),
        .force_len(force_len), .rate_sel(rate_sel), .zc_evt(zc_evt), .min_gap(min_gap),
        .mode(mode), .step(step), .out_en(out_en), .spd_pulse(spd_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic zc_pulse();
        zc_evt = 1'b1;
        @(negedge clk);
        zc_evt = 1'b0;
    endtask

    // leaves the bench at the first cycle of forced mode
    task automatic enter_force();
        start_req = 1'b0;
        tick(2);
        start_req = 1'b1;
        tick(11);
    endtask

    // forced mode at P=8, two zero-crossings 4 apart -> run
    task automatic enter_run();
        rate_sel = 2'd0;
        enter_force();
        zc_pulse();
        tick(3);
        zc_pulse();
    endtask

    task automatic t_reset();
        check("R1 reset mode", mode, 0);
        check("R1 reset step", step, 0);
        check("R1 reset spd", spd_pulse, 0);
        check("R1 reset en", out_en, 0);
        tick(10);
        check("R1 idle held", mode, 0);
    endtask

    task automatic t_align_force_timeout();
        rate_sel = 2'd0;
        start_req = 1'b1;
        tick(1);
        check("R2 align entry", mode, 1);
        check("R2 align enable", out_en, 1);
        tick(9);
        check("R2 align length", mode, 1);
        check("R2 align step", step, 0);
        tick(1);
        check("R2 to forced", mode, 2);
        tick(7);
        check("R3 before first step", step, 0);
        tick(1);
        check("R3 first step", step, 1);
        check("R10 spd toggle", spd_pulse, 1);
        tick(16);
        check("R3 third step", step, 3);
        tick(275);
        check("R5 before timeout", mode, 2);
        tick(1);
        check("R5 timeout fault", mode, 4);
        check("R9 fault disables", out_en, 0);
        tick(49);
        check("R9 still fault", mode, 4);
        tick(1);
        check("R9 restart align", mode, 1);
    endtask

    task automatic t_rate_sel();
        rate_sel = 2'd1;
        enter_force();
        tick(15);
        check("R3 sel1 before", step, 0);
        tick(1);
        check("R3 sel1 step", step, 1);
        rate_sel = 2'd3;
        enter_force();
        tick(31);
        check("R3 sel3 before", step, 0);
        tick(1);
        check("R3 sel3 acts as 2", step, 1);
    endtask

    task automatic t_handover_run();
        int s;
        rate_sel = 2'd0;
        enter_force();
        zc_pulse();
        tick(11);
        zc_pulse();
        check("R4 slow gap no handover", mode, 2);
        tick(4);
        zc_pulse();
        check("R4 handover", mode, 3);
        check("R4 handover step", step, 3);
        s = spd_pulse;
        tick(5);
        zc_pulse();
        check("R6 run step", step, 4);
        check("R10 run spd", spd_pulse, 1 - s);
        tick(5);
        zc_pulse();
        tick(5);
        zc_pulse();
        check("R6 wrap", step, 0);
        tick(1);
        zc_pulse();
        check("R7 overspeed fault", mode, 4);
        check("R7 step held", step, 0);
        check("R7 outputs off", out_en, 0);
    endtask

    task automatic t_underspeed();
        enter_run();
        check("R8 in run", mode, 3);
        tick(6);
        check("R8 short quiet ok", mode, 3);
        tick(14);
        check("R8 underspeed fault", mode, 4);
    endtask

    task automatic t_release_vs_fault();
        enter_run();
        tick(1);
        start_req = 1'b0;
        zc_pulse();
        check("R11 release wins", mode, 0);
        check("R11 outputs off", out_en, 0);
        tick(5);
        check("R1 idle stays", mode, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_align_force_timeout();
        t_rate_sel();
        t_handover_run();
        t_underspeed();
        t_release_vs_fault();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule